// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared, arbitrated bus. Each direct-mapped line slot holds a tag and one of four states: Modified, Exclusive-clean, Shared or Invalid. Processor reads and writes that hit with enough permission finish in the same cycle and cause no bus traffic. Other accesses raise a bus request carrying a read, read-exclusive, invalidate or write-back command. The processor is held until the grant arrives.

A bus transaction is atomic: it completes in the cycle in which it is granted. In that cycle the controller samples a wired-OR shared input, so a read fill lands in Exclusive-clean when no peer holds the line and in Shared when one does. The controller also watches transactions issued by other caches on a snoop port. On a foreign read it drives its own contribution to the shared wire and supplies dirty data. On a foreign read-exclusive or invalidate it drops its copy. The data array, the replacement policy and the arbiter lie outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every slot is Invalid. A snooped read sees no copy, and every first local access needs a bus transaction.
- R2: A local read that misses raises bus_req with bus_cmd 1 (read) and the line address, where the index is the low address bits and the tag is the rest. cpu_done stays low until the cycle in which bus_gnt is high, and rises in that cycle.
- R3: On a read fill, the line becomes Exclusive-clean if bus_shared_in is low in the grant cycle and Shared if it is high. A later write to a Shared line needs a bus transaction.
- R4: A local read that hits a Modified, Exclusive-clean or Shared line completes in the same cycle with no bus request.
- R5: A local write to an Exclusive-clean line completes in the same cycle with no bus request, and the line becomes Modified.
- R6: A local write to a Shared line requests the bus with bus_cmd 3 (invalidate). It completes on the grant, and the line becomes Modified.
- R7: A local write that misses requests the bus with bus_cmd 2 (read-exclusive). It completes on the grant, and the line becomes Modified.
- R8: A snooped read (snp_cmd 1) that hits a valid line drives snp_shared_out high in the same cycle. If the line is Modified, snp_flush is also high, and every hit line moves to Shared.
- R9: A snooped read-exclusive (2) or invalidate (3) that hits moves the line to Invalid, and snp_flush is high if the line was Modified.
- R10: A snoop that misses in tag, hits an Invalid slot, or carries write-back (4) drives neither output and leaves the line unchanged.
- R11: A miss whose slot holds a Modified line with another tag first issues bus_cmd 4 (write-back) with the victim's address. The slot becomes Invalid on that grant, and the fill follows.
- R12: A snoop to the same slot index as the pending local request in the same cycle takes priority: cpu_done and bus_req are low in that cycle.
- R13: Only one transaction is on the bus at a time. bus_gnt comes only while bus_req is high and never together with a foreign snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request, held until cpu_done |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 3 | Command: 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared signal from the other caches |
| snp_valid | input | 1 | Foreign transaction on the bus |
| snp_cmd | input | 3 | Foreign command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Foreign line address |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data |

## Verification
Hits, grants and snoop responses all appear combinationally in the cycle of their stimulus. State changes appear only from the following cycle, when the next access or snoop is decoded against them. The bench therefore drives inputs one time unit after a rising edge and reads the responses within that same cycle, before the next edge. It uses later accesses and snoops to show each state: a silent write reveals Exclusive-clean, an invalidate request reveals Shared, and a flush reveals Modified. For misses it counts the cycles until cpu_done against the grant delay it chose, and it requires cpu_done to stay low in every cycle without a grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RDX  = 3'd2,
    OP_UPG  = 3'd3,
    OP_WB   = 3'd4
  } bus_op_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_t         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_t         rb_st,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_t         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [TAG_W-1:0] wb_tag,
  input  line_st_t         wb_st
);
  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_d [LINES];
  line_st_t         st_d  [LINES];

  // Port A (snoop side) wins over port B (local side) on the same slot.
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      tag_d[i] = tag_q[i];
      st_d[i]  = st_q[i];
      if (wa_en && wa_idx == IDX_W'(i)) begin
        st_d[i] = wa_st;
      end else if (wb_en && wb_idx == IDX_W'(i)) begin
        st_d[i]  = wb_st;
        tag_d[i] = wb_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= tag_d[i];
        st_q[i]  <= st_d[i];
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];

  // R9: a snoop-side update is visible in the slot one cycle later
  p_snoop_update_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |=> st_q[$past(wa_idx)] == $past(wa_st));
endmodule

// File: rtl/mesi_local_ctrl.sv
module mesi_local_ctrl
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] ln_tag,
  input  line_st_t         ln_st,
  input  logic             hold,
  input  logic             bus_gnt,
  input  logic             bus_shared,
  output logic             done,
  output logic             breq,
  output bus_op_t          op,
  output logic [TAG_W-1:0] addr_tag,
  output logic             upd,
  output line_st_t         nst,
  output logic [TAG_W-1:0] ntag
);
  logic tag_hit;
  assign tag_hit = (ln_st != ST_I) && (ln_tag == req_tag);

  always_comb begin
    done     = 1'b0;
    breq     = 1'b0;
    op       = OP_NONE;
    addr_tag = req_tag;
    upd      = 1'b0;
    nst      = ln_st;
    ntag     = ln_tag;
    if (req_valid && !hold) begin
      if (tag_hit) begin
        case (ln_st)
          ST_M: done = 1'b1;
          ST_E: begin
            done = 1'b1;
            if (req_write) begin
              upd = 1'b1;
              nst = ST_M;
            end
          end
          ST_S: begin
            if (!req_write) begin
              done = 1'b1;
            end else begin
              breq = 1'b1;
              op   = OP_UPG;
              if (bus_gnt) begin
                done = 1'b1;
                upd  = 1'b1;
                nst  = ST_M;
              end
            end
          end
          default: ;
        endcase
      end else if (ln_st == ST_M) begin
        breq     = 1'b1;
        op       = OP_WB;
        addr_tag = ln_tag;
        if (bus_gnt) begin
          upd = 1'b1;
          nst = ST_I;
        end
      end else begin
        breq = 1'b1;
        op   = req_write ? OP_RDX : OP_RD;
        if (bus_gnt) begin
          done = 1'b1;
          upd  = 1'b1;
          ntag = req_tag;
          nst  = req_write ? ST_M : (bus_shared ? ST_S : ST_E);
        end
      end
    end
  end

  // R2: while a bus request is open, completion only comes with the grant
  p_stall_until_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && breq) |-> bus_gnt);
  // R11: a write-back never completes the processor request
  p_wb_not_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (breq && op == OP_WB) |-> !done);
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snp_valid,
  input  bus_op_t          snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] ln_tag,
  input  line_st_t         ln_st,
  output logic             shared_out,
  output logic             flush,
  output logic             upd,
  output line_st_t         nst
);
  logic hit;
  assign hit = snp_valid && (ln_st != ST_I) && (ln_tag == snp_tag);

  always_comb begin
    shared_out = 1'b0;
    flush      = 1'b0;
    upd        = 1'b0;
    nst        = ln_st;
    if (hit) begin
      case (snp_op)
        OP_RD: begin
          shared_out = 1'b1;
          flush      = (ln_st == ST_M);
          upd        = 1'b1;
          nst        = ST_S;
        end
        OP_RDX, OP_UPG: begin
          flush = (ln_st == ST_M);
          upd   = 1'b1;
          nst   = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared_out,
  output logic              snp_flush
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0] cpu_ln_tag, snp_ln_tag, loc_ntag, loc_atag;
  line_st_t         cpu_ln_st, snp_ln_st, loc_nst, snp_nst;
  logic             loc_upd, snp_upd, snoop_hold;
  bus_op_t          loc_op;

  // snoop to the same slot wins over the local access this cycle
  assign snoop_hold = snp_valid && (snp_idx == cpu_idx);

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ra_idx (snp_idx),
    .ra_tag (snp_ln_tag),
    .ra_st  (snp_ln_st),
    .rb_idx (cpu_idx),
    .rb_tag (cpu_ln_tag),
    .rb_st  (cpu_ln_st),
    .wa_en  (snp_upd),
    .wa_idx (snp_idx),
    .wa_st  (snp_nst),
    .wb_en  (loc_upd),
    .wb_idx (cpu_idx),
    .wb_tag (loc_ntag),
    .wb_st  (loc_nst)
  );

  mesi_local_ctrl #(.TAG_W(TAG_W)) u_local (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (cpu_req_valid),
    .req_write  (cpu_req_write),
    .req_tag    (cpu_tag),
    .ln_tag     (cpu_ln_tag),
    .ln_st      (cpu_ln_st),
    .hold       (snoop_hold),
    .bus_gnt    (bus_gnt),
    .bus_shared (bus_shared_in),
    .done       (cpu_done),
    .breq       (bus_req),
    .op         (loc_op),
    .addr_tag   (loc_atag),
    .upd        (loc_upd),
    .nst        (loc_nst),
    .ntag       (loc_ntag)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid  (snp_valid),
    .snp_op     (bus_op_t'(snp_cmd)),
    .snp_tag    (snp_tag),
    .ln_tag     (snp_ln_tag),
    .ln_st      (snp_ln_st),
    .shared_out (snp_shared_out),
    .flush      (snp_flush),
    .upd        (snp_upd),
    .nst        (snp_nst)
  );

  assign bus_cmd  = loc_op;
  assign bus_addr = {loc_atag, cpu_idx};

  // R12: a same-slot snoop stalls the local side for that cycle
  p_snoop_first_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (snp_valid && cpu_req_valid && snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0])
      |-> (!cpu_done && !bus_req));
  // R13: one atomic transaction at a time, granted only on request
  p_atomic_bus_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_gnt |-> (bus_req && !snp_valid));
  // R10: a foreign write-back draws no response
  p_wb_snoop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (snp_valid && snp_cmd == 3'd4) |-> (!snp_flush && !snp_shared_out));
  // R4: a read completing without a grant never leaves a bus request open
  p_read_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_done && !cpu_req_write && !bus_gnt) |-> !bus_req);
endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0] cpu_req_addr = '0;
  logic       cpu_done, bus_req;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr;
  logic       bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0;
  logic [2:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;
  logic       snp_shared_out, snp_flush;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int         nreq, ncyc, stall_bad;
  logic [2:0] c0, c1;
  logic [7:0] a0;
  logic       s_sh, s_fl;

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl u_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared_out(snp_shared_out), .snp_flush(snp_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // processor access with a simple arbiter: grant after dly waiting cycles
  task automatic cpu_op(input logic w, input logic [7:0] a, input int dly, input logic sh);
    int waitc = 0;
    bit got = 1'b0;
    nreq = 0; ncyc = -1; stall_bad = 0; c0 = '0; c1 = '0; a0 = '0;
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
    for (int k = 0; k < 40 && !got; k++) begin
      #1;
      if (bus_req) begin
        if (waitc >= dly) begin
          bus_gnt = 1'b1; bus_shared_in = sh;
          if (nreq == 0) begin c0 = bus_cmd; a0 = bus_addr; end
          else c1 = bus_cmd;
          nreq++; waitc = 0;
        end else begin
          waitc++;
        end
      end
      #1;
      if (cpu_done && !bus_gnt && bus_req) stall_bad++;
      if (cpu_done) begin got = 1'b1; ncyc = k; end
      @(posedge clk); #1;
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
    end
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [7:0] a);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #2;
    s_sh = snp_shared_out; s_fl = snp_flush;
    @(posedge clk); #1;
    snp_valid = 1'b0; snp_cmd = '0;
  endtask

  task automatic t_reset;
    @(posedge clk); #3;
    chk("R1 done idle", int'(cpu_done), 0);
    chk("R1 bus_req idle", int'(bus_req), 0);
    snoop(3'd1, 8'h00);
    chk("R1 snoop sees no copy", int'(s_sh), 0);
    cpu_op(1'b0, 8'h00, 0, 1'b0);
    chk("R1 first access uses bus", nreq, 1);
  endtask

  task automatic t_exclusive_path;
    cpu_op(1'b0, 8'h10, 2, 1'b0);
    chk("R2 read miss cmd", int'(c0), 1);
    chk("R2 read miss addr", int'(a0), 'h10);
    chk("R2 done on grant cycle", ncyc, 2);
    chk("R2 no early done", stall_bad, 0);
    cpu_op(1'b1, 8'h10, 0, 1'b0);
    chk("R3 R5 exclusive write silent", nreq, 0);
    chk("R5 exclusive write same cycle", ncyc, 0);
    snoop(3'd1, 8'h10);
    chk("R8 shared out on read snoop", int'(s_sh), 1);
    chk("R5 R8 modified flushes", int'(s_fl), 1);
    cpu_op(1'b1, 8'h10, 1, 1'b0);
    chk("R8 R6 shared write upgrade cmd", int'(c0), 3);
    chk("R6 upgrade done on grant", ncyc, 1);
    snoop(3'd2, 8'h10);
    chk("R6 R9 modified flushes on rdx", int'(s_fl), 1);
    chk("R9 no shared on rdx", int'(s_sh), 0);
    cpu_op(1'b0, 8'h10, 0, 1'b0);
    chk("R9 invalidated line misses", int'(c0), 1);
  endtask

  task automatic t_shared_fill;
    cpu_op(1'b0, 8'h21, 0, 1'b1);
    chk("R2 shared fill cmd", int'(c0), 1);
    cpu_op(1'b0, 8'h21, 0, 1'b0);
    chk("R4 read hit no bus", nreq, 0);
    chk("R4 read hit same cycle", ncyc, 0);
    cpu_op(1'b1, 8'h21, 0, 1'b0);
    chk("R3 shared fill needs upgrade", int'(c0), 3);
    snoop(3'd3, 8'h21);
    chk("R9 invalidate flushes modified", int'(s_fl), 1);
    snoop(3'd1, 8'h21);
    chk("R9 line gone after invalidate", int'(s_sh), 0);
  endtask

  task automatic t_write_miss;
    cpu_op(1'b1, 8'h32, 0, 1'b0);
    chk("R7 write miss cmd", int'(c0), 2);
    chk("R7 write miss done", ncyc, 0);
    snoop(3'd1, 8'h12);
    chk("R10 tag miss no shared", int'(s_sh), 0);
    chk("R10 tag miss no flush", int'(s_fl), 0);
    snoop(3'd2, 8'h12);
    chk("R10 tag miss rdx no flush", int'(s_fl), 0);
    snoop(3'd4, 8'h32);
    chk("R10 wb snoop no flush", int'(s_fl), 0);
    chk("R10 wb snoop no shared", int'(s_sh), 0);
    snoop(3'd1, 8'h32);
    chk("R7 R10 line still modified", int'(s_fl), 1);
  endtask

  task automatic t_writeback;
    cpu_op(1'b1, 8'h03, 0, 1'b0);
    cpu_op(1'b0, 8'h13, 0, 1'b0);
    chk("R11 victim write-back cmd", int'(c0), 4);
    chk("R11 victim address", int'(a0), 'h03);
    chk("R11 fill follows", int'(c1), 1);
    chk("R11 two transactions", nreq, 2);
    snoop(3'd1, 8'h03);
    chk("R11 victim slot released", int'(s_sh), 0);
    snoop(3'd1, 8'h13);
    chk("R11 new line present", int'(s_sh), 1);
  endtask

  task automatic t_snoop_priority;
    cpu_op(1'b0, 8'h41, 0, 1'b0);
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h41;
    snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = 8'h01;
    #2;
    chk("R12 same slot snoop blocks done", int'(cpu_done), 0);
    chk("R12 same slot snoop blocks req", int'(bus_req), 0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    #2;
    chk("R12 done after snoop clears", int'(cpu_done), 1);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = 8'h02;
    #2;
    chk("R12 other slot snoop no block", int'(cpu_done), 1);
    @(posedge clk); #1;
    snp_valid = 1'b0; cpu_req_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_fill();
    t_write_miss();
    t_writeback();
    t_snoop_priority();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule